// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block serializes one data word per frame onto a single output line. A frame has a low start bit, 7 or 8 data bits sent least-significant bit first, an optional odd or even parity bit made in hardware, and a high stop bit. Between frames the line rests high. A set of control inputs configures and drives the block. An enable level holds it in reset while low and makes it ready while high. A one-cycle trigger pulse starts a frame, and a sticky completion flag can raise an interrupt.

Bit timing comes from one of several baud-tick inputs, picked by a select field. The block sends one frame bit per selected tick and ignores the ticks it has not selected. Software loads the data word, pulses the trigger, and then waits for the completion flag or the interrupt. It clears the flag by pulsing a write-one clear input, and it drops the enable when it has finished.

Top module: `async_tx`

## Requirements
- R1: After reset, `txOut` is 1, `busy` is 0 and `doneFlag` is 0. Whenever `busy` is 0, `txOut` is 1.
- R2: A `trigger` pulse while `txEnable` is 1 and `busy` is 0 makes `busy` 1 from the next cycle. The first selected tick after that drives `txOut` to 0, which is the start bit.
- R3: With `len8`=1, each of the next 8 selected ticks drives `dataIn[0]` through `dataIn[7]` onto `txOut`, in that order.
- R4: With `len8`=0, exactly 7 data bits (`dataIn[0]` through `dataIn[6]`) are sent, and `dataIn[7]` has no effect on the line.
- R5: With `parEn`=1, the tick after the last data bit drives a parity bit. For `parOdd`=0 the parity bit is the XOR of the sent data bits, and for `parOdd`=1 it is the inverse of that XOR. With `parEn`=0 no parity bit is sent, and the stop bit follows the data at once.
- R6: The stop bit is 1 and lasts one tick period. At the next selected tick the frame completes: `doneFlag` becomes 1 and `busy` becomes 0 on the same edge.
- R7: `irq` is 1 exactly while `doneFlag` is 1 and `irqEnable` is 1.
- R8: `doneFlag` stays 1 until `doneClear` is pulsed. If the completion and the clear fall in the same cycle, the flag ends up set.
- R9: `txEnable`=0 aborts any frame. From the next cycle `busy` is 0, `txOut` is 1 and `doneFlag` is 0.
- R10: `trigger` is ignored while `txEnable` is 0 or `busy` is 1. A frame in progress continues with its original data.
- R11: `clkSel` picks which bit of `baudTick` paces the frame. Pulses on the other bits do not change `txOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baudTick | input | NUM_SRC | One-cycle baud pulses, one per clock source |
| clkSel | input | SEL_W | Index of the tick source that paces the frame |
| txEnable | input | 1 | 0 holds the transmitter reset, 1 makes it ready |
| trigger | input | 1 | One-cycle pulse that starts a frame |
| dataIn | input | DATA_W | Word to send, captured at the trigger |
| len8 | input | 1 | 1 = 8 data bits, 0 = 7 data bits |
| parEn | input | 1 | 1 appends a parity bit |
| parOdd | input | 1 | 1 = odd parity, 0 = even parity |
| irqEnable | input | 1 | Allows the completion flag onto `irq` |
| doneClear | input | 1 | Write-one pulse that clears `doneFlag` |
| txOut | output | 1 | Serial line, high when idle |
| busy | output | 1 | A frame is pending or being sent |
| doneFlag | output | 1 | Sticky frame-complete flag |
| irq | output | 1 | Interrupt request |

## Verification
The completion of a frame and a software clear of the completion flag can land on the same clock edge. The bench provokes this by holding `doneClear` high during the very tick that ends the stop bit. It then requires `doneFlag` to read 1 afterwards, because the set takes priority. A second overlap is a trigger arriving mid-frame. The bench judges that case by checking that the frame's remaining bits still match the data word originally loaded.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;
  typedef struct packed {
    logic load;
    logic sendStart;
    logic sendData;
    logic sendParity;
    logic sendStop;
    logic abort;
  } txStrobe_t;
endpackage

// File: rtl/async_tx_ctrl.sv
module async_tx_ctrl
  import async_tx_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int DATA_W  = 8,
  localparam int SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM_SRC-1:0] baudTick,
  input  logic [SEL_W-1:0] clkSel,
  input  logic             txEnable,
  input  logic             trigger,
  input  logic             len8,
  input  logic             parEn,
  input  logic             doneClear,
  output txStrobe_t        strobe,
  output logic             busy,
  output logic             doneFlag
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] LAST_NARROW = CNT_W'(DATA_W - 2);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_START, S_DATA, S_PAR, S_STOP} txState_t;

  txState_t state, stateNext;
  logic [CNT_W-1:0] bitCnt, bitCntNext;
  logic cfgLen8, cfgPar;
  logic tick, finish;
  logic [CNT_W-1:0] lastIdx;

  assign tick    = baudTick[clkSel];
  assign lastIdx = cfgLen8 ? LAST_WIDE : LAST_NARROW;
  assign busy    = (state != S_IDLE);

  always_comb begin
    stateNext  = state;
    bitCntNext = bitCnt;
    strobe     = '0;
    finish     = 1'b0;
    if (!txEnable) begin
      stateNext    = S_IDLE;
      bitCntNext   = '0;
      strobe.abort = 1'b1;
    end else begin
      unique case (state)
        S_IDLE: if (trigger) begin
          stateNext   = S_WAIT;
          strobe.load = 1'b1;
        end
        S_WAIT: if (tick) begin
          stateNext        = S_START;
          strobe.sendStart = 1'b1;
        end
        S_START: if (tick) begin
          stateNext       = S_DATA;
          bitCntNext      = '0;
          strobe.sendData = 1'b1;
        end
        S_DATA: if (tick) begin
          if (bitCnt == lastIdx) begin
            if (cfgPar) begin
              stateNext         = S_PAR;
              strobe.sendParity = 1'b1;
            end else begin
              stateNext       = S_STOP;
              strobe.sendStop = 1'b1;
            end
          end else begin
            bitCntNext      = bitCnt + 1'b1;
            strobe.sendData = 1'b1;
          end
        end
        S_PAR: if (tick) begin
          stateNext       = S_STOP;
          strobe.sendStop = 1'b1;
        end
        S_STOP: if (tick) begin
          stateNext = S_IDLE;
          finish    = 1'b1;
        end
        default: stateNext = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      bitCnt   <= '0;
      cfgLen8  <= 1'b1;
      cfgPar   <= 1'b0;
      doneFlag <= 1'b0;
    end else begin
      state  <= stateNext;
      bitCnt <= bitCntNext;
      if (strobe.load) begin
        cfgLen8 <= len8;
        cfgPar  <= parEn;
      end
      if (!txEnable)      doneFlag <= 1'b0;
      else if (finish)    doneFlag <= 1'b1;
      else if (doneClear) doneFlag <= 1'b0;
    end
  end

  // R9: a low enable resets the frame and the flag
  a_r9_enable_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !txEnable |=> (!busy && !doneFlag));

  // R6: the flag only rises at the end of a frame
  a_r6_done_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(doneFlag) |-> $past(busy));

  // R8: a normal end of frame always leaves the flag set, even against a clear
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && $past(txEnable)) |-> doneFlag);

  // R10: a trigger during a frame never restarts it at the load step
  a_r10_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !strobe.load);
endmodule

// File: rtl/async_tx_dp.sv
module async_tx_dp
  import async_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  txStrobe_t         strobe,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              len8,
  input  logic              parOdd,
  output logic              txOut
);
  logic [DATA_W-1:0] shiftReg, masked;
  logic parBit;

  assign masked = len8 ? dataIn : {1'b0, dataIn[DATA_W-2:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
      txOut    <= 1'b1;
    end else begin
      if (strobe.load) begin
        shiftReg <= masked;
        parBit   <= (^masked) ^ parOdd;
      end
      if (strobe.abort || strobe.sendStop) txOut <= 1'b1;
      else if (strobe.sendStart)           txOut <= 1'b0;
      else if (strobe.sendParity)          txOut <= parBit;
      else if (strobe.sendData) begin
        txOut    <= shiftReg[0];
        shiftReg <= shiftReg >> 1;
      end
    end
  end

  // R2: the start strobe yields a low line
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.sendStart |=> !txOut);

  // R6: the stop strobe yields a high line
  a_r6_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.sendStop |=> txOut);
endmodule

// File: rtl/async_tx.sv
module async_tx
  import async_tx_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int DATA_W  = 8,
  localparam int SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] baudTick,
  input  logic [SEL_W-1:0]   clkSel,
  input  logic               txEnable,
  input  logic               trigger,
  input  logic [DATA_W-1:0]  dataIn,
  input  logic               len8,
  input  logic               parEn,
  input  logic               parOdd,
  input  logic               irqEnable,
  input  logic               doneClear,
  output logic               txOut,
  output logic               busy,
  output logic               doneFlag,
  output logic               irq
);
  txStrobe_t strobe;

  async_tx_ctrl #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rst_n(rst_n), .baudTick(baudTick), .clkSel(clkSel),
    .txEnable(txEnable), .trigger(trigger), .len8(len8), .parEn(parEn),
    .doneClear(doneClear), .strobe(strobe), .busy(busy), .doneFlag(doneFlag)
  );

  async_tx_dp #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .dataIn(dataIn),
    .len8(len8), .parOdd(parOdd), .txOut(txOut)
  );

  assign irq = doneFlag && irqEnable;

  // R1: the line rests high whenever no frame is pending
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txOut);
endmodule

// File: tb/sim_async_tx.sv
module sim_async_tx;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {sel[1:0], parOdd, parEn, len8, data[7:0]}
  localparam logic [12:0] VEC [NVEC] = '{
    {2'd0, 1'b0, 1'b0, 1'b1, 8'hA5},
    {2'd1, 1'b0, 1'b1, 1'b1, 8'h3C},
    {2'd2, 1'b1, 1'b1, 1'b1, 8'h3C},
    {2'd3, 1'b0, 1'b1, 1'b0, 8'hFF},
    {2'd0, 1'b1, 1'b1, 1'b0, 8'h80},
    {2'd1, 1'b1, 1'b1, 1'b1, 8'h01}
  };

  logic clk = 0, rst_n = 0;
  logic [3:0] baudTick = '0;
  logic [1:0] clkSel = '0;
  logic txEnable = 0, trigger = 0, len8 = 1, parEn = 0, parOdd = 0;
  logic irqEnable = 0, doneClear = 0;
  logic [7:0] dataIn = '0;
  logic txOut, busy, doneFlag, irq;
  int checks = 0, errors = 0;

  async_tx u0 (.clk(clk), .rst_n(rst_n), .baudTick(baudTick), .clkSel(clkSel),
    .txEnable(txEnable), .trigger(trigger), .dataIn(dataIn), .len8(len8),
    .parEn(parEn), .parOdd(parOdd), .irqEnable(irqEnable), .doneClear(doneClear),
    .txOut(txOut), .busy(busy), .doneFlag(doneFlag), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse(input int idx, input logic clr = 1'b0);
    @(negedge clk);
    baudTick = 4'b1 << idx;
    doneClear = clr;
    @(negedge clk);
    baudTick = '0;
    doneClear = 1'b0;
  endtask

  task automatic fire();
    @(negedge clk);
    trigger = 1'b1;
    @(negedge clk);
    trigger = 1'b0;
  endtask

  function automatic logic expBit(input logic [7:0] d, input logic w, input logic p,
                                  input logic po, input int i);
    logic [7:0] m;
    int n;
    m = w ? d : {1'b0, d[6:0]};
    n = w ? 8 : 7;
    if (i == 0) return 1'b0;
    if (i <= n) return m[i-1];
    if (p && i == n + 1) return (^m) ^ po;
    return 1'b1;
  endfunction

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [12:0] v;
    int nb;
    repeat (3) @(negedge clk);
    check(txOut === 1'b1, "R1 reset txOut", txOut, 1);
    check(busy === 1'b0, "R1 reset busy", busy, 0);
    check(doneFlag === 1'b0, "R1 reset done", doneFlag, 0);
    rst_n = 1;
    @(negedge clk);

    // R10: trigger with enable low is ignored
    fire();
    check(busy === 1'b0, "R10 trigger while disabled", busy, 0);
    pulse(0);
    check(txOut === 1'b1, "R10 no start while disabled", txOut, 1);
    txEnable = 1;

    // vector table: R2 R3 R4 R5 R6 R11
    for (int k = 0; k < NVEC; k++) begin
      v = VEC[k];
      dataIn = v[7:0]; len8 = v[8]; parEn = v[9]; parOdd = v[10]; clkSel = v[12:11];
      nb = 2 + (len8 ? 8 : 7) + (parEn ? 1 : 0);
      fire();
      check(busy === 1'b1, "R2 busy after trigger", busy, 1);
      dataIn = ~v[7:0];
      pulse((int'(clkSel) + 1) % 4);
      check(txOut === 1'b1, "R11 unselected tick ignored", txOut, 1);
      for (int i = 0; i < nb; i++) begin
        pulse(int'(clkSel));
        check(txOut === expBit(v[7:0], v[8], v[9], v[10], i),
              "R3 R4 R5 frame bit", txOut, expBit(v[7:0], v[8], v[9], v[10], i));
        pulse((int'(clkSel) + 2) % 4);
        check(txOut === expBit(v[7:0], v[8], v[9], v[10], i),
              "R11 line held between ticks", txOut, expBit(v[7:0], v[8], v[9], v[10], i));
      end
      check(busy === 1'b1, "R6 busy through stop", busy, 1);
      pulse(int'(clkSel));
      check(doneFlag === 1'b1, "R6 done at completion", doneFlag, 1);
      check(busy === 1'b0, "R6 idle at completion", busy, 0);
      check(irq === 1'b0, "R7 irq masked", irq, 0);
      pulse(0, 1'b1);
      check(doneFlag === 1'b0, "R8 write-one clear", doneFlag, 0);
    end

    // R10: trigger mid-frame is ignored; R7 irq; R8 set beats clear
    dataIn = 8'h96; len8 = 1; parEn = 0; parOdd = 0; clkSel = 0; irqEnable = 1;
    fire();
    pulse(0);
    pulse(0);
    dataIn = 8'h00;
    fire();
    for (int i = 2; i < 10; i++) begin
      pulse(0);
      check(txOut === expBit(8'h96, 1'b1, 1'b0, 1'b0, i), "R10 frame survives trigger",
            txOut, expBit(8'h96, 1'b1, 1'b0, 1'b0, i));
    end
    pulse(0, 1'b1);
    check(doneFlag === 1'b1, "R8 set wins over clear", doneFlag, 1);
    check(irq === 1'b1, "R7 irq raised", irq, 1);
    pulse(3);
    check(doneFlag === 1'b1, "R8 flag sticky", doneFlag, 1);
    irqEnable = 0;
    @(negedge clk);
    check(irq === 1'b0, "R7 irq follows enable", irq, 0);

    // R9: enable low aborts a frame and clears the flag
    dataIn = 8'h00;
    fire();
    pulse(0);
    check(txOut === 1'b0, "R9 start bit before abort", txOut, 0);
    txEnable = 0;
    @(negedge clk);
    check(busy === 1'b0, "R9 abort busy", busy, 0);
    check(txOut === 1'b1, "R9 abort line high", txOut, 1);
    check(doneFlag === 1'b0, "R9 abort clears flag", doneFlag, 0);
    txEnable = 1;
    pulse(0);
    check(txOut === 1'b1, "R1 idle after abort", txOut, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule